// File: doc/BRIEF.md
# Boot ROM Window Decoder

This block decides, for every bus cycle on an S-100 style backplane, whether a boot EPROM card should answer. At the clock edge where the cycle-start strobe (pSYNC) is high it captures the address and the memory-read status. It then compares the upper address bits against a value from a bank of DIP switches. Only the bits from A18 down to the bottom of the selected window take part. A jumper value sets the window size at 2kB, 4kB or 8kB, inside an 8kB EPROM. With the switches at 0x1F and the smallest window, the ROM covers F800h to FFFFh.

On a memory read that hits the window, the block enables the EPROM and pulls the bus Phantom line low, so that any RAM at the same address stays off the bus. The EPROM output enable is also gated by the data-in strobe (pDBIN), so the card drives data only during the read data phase. The block maps the window onto the top of the device, so a 2kB window uses the last 2kB of the 8kB part.

Address lines above A18 are never compared. The ROM therefore repeats every 512kB, and this is intended.

Top module: `boot_rom_decode`

## Requirements
- R1: While rst_n is low at a clock edge, the captured cycle is cleared, and afterwards rom_ce_n, rom_oe_n and phantom_n are all high.
- R2: Address and memory-read status are captured only at a rising clock edge where psync is high. They are held until the next such edge, so changes at the inputs between pSYNC edges have no effect on the outputs.
- R3: A cycle hits when its captured memory-read status is 1 and the captured address bits A18 down to A(11+k) equal base_sw bits 7 down to k. Here base_sw bit i corresponds to address bit A(11+i), and k is the window code.
- R4: win_sel encoding: 2'b00 selects a 2kB window (k=0), 2'b01 a 4kB window (k=1), and 2'b10 or 2'b11 an 8kB window (k=2). Address bits below the window and the switch bits facing them are ignored.
- R5: Address bits A19 and above are ignored. With base_sw=0x1F and a 2kB window, 08F800h and F8F800h hit, while 04F800h (A18 set) misses.
- R6: phantom_n is low (asserted) exactly while the captured cycle hits. A write or I/O cycle (memory-read status 0) never asserts it, even at a matching address.
- R7: rom_ce_n is low exactly while the captured cycle hits.
- R8: rom_oe_n is low only while the captured cycle hits and dbin is high. It follows dbin in the same cycle, with no register on that path.
- R9: rom_addr[12:0] carries the captured A12..A0, except that the bits at or above the window size are forced to 1. For example, with a 2kB window, bits 12:11 are 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 24 | Bus address lines A23..A0 |
| smemr | input | 1 | Memory-read status of the current cycle |
| psync | input | 1 | Cycle start strobe, high during address phase |
| dbin | input | 1 | Read data strobe |
| base_sw | input | 8 | Switch value matched against A18..A11 |
| win_sel | input | 2 | Jumper code for window size |
| rom_ce_n | output | 1 | EPROM chip enable, active low |
| rom_oe_n | output | 1 | EPROM output enable, active low |
| rom_addr | output | 13 | Address to the EPROM |
| phantom_n | output | 1 | Bus Phantom, active low, disables RAM |

## Verification
The hardest cases to reach are the ones where the match depends only on bits that the window excludes. Examples are an address whose A11 differs from the switch under a 4kB window, and one whose A12 differs under an 8kB window. A plain read at F800h never exercises the masking. The stimulus therefore reuses the same switch value with addresses chosen to differ only below the window boundary. It repeats each address under a smaller window, where the same access must miss. Aliasing is reached by driving bus bits above A18 while keeping the lower bits on the window.

// File: rtl/boot_rom_pkg.sv
// Shared constants and helpers for the boot ROM window decoder.
// Assumes windows are powers of two between 2^MIN_AW and 2^MAX_AW bytes.
package boot_rom_pkg;

    // Jumper codes for the window size
    typedef enum logic [1:0] {
        WIN_2K = 2'b00,
        WIN_4K = 2'b01,
        WIN_8K = 2'b10,
        WIN_8K_ALT = 2'b11
    } win_code_e;

    // Number of low address bits left out of the compare for a jumper code
    function automatic int unsigned window_bits(input logic [1:0] code,
                                                input int unsigned min_aw,
                                                input int unsigned max_aw);
        int unsigned w;
        w = min_aw + int'(code);
        if (w > max_aw) w = max_aw;
        return w;
    endfunction

endpackage

// File: rtl/brd_cycle_latch.sv
// Captures the bus address and memory-read status at the start of a cycle.
// Assumes psync is high for the clock edge that opens each bus cycle; the
// captured values are held until the next such edge.
module brd_cycle_latch #(
    parameter int BUS_AW = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psync,
    input  logic [BUS_AW-1:0] addr_in,
    input  logic              memr_in,
    output logic [BUS_AW-1:0] cyc_addr,
    output logic              cyc_memr
);

    // Hold address and status of the current bus cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_addr <= '0;
            cyc_memr <= 1'b0;
        end else if (psync) begin
            cyc_addr <= addr_in;
            cyc_memr <= memr_in;
        end
    end

endmodule

// File: rtl/brd_window_match.sv
// Compares the decoded address bits against the switch value.
// Switch bit i faces address bit MIN_AW+i; bits below the window size
// chosen by the jumper code are excluded. Bits at or above DEC_AW are
// never seen, which makes the window repeat every 2^DEC_AW bytes.
module brd_window_match
    import boot_rom_pkg::*;
#(
    parameter int DEC_AW = 19,
    parameter int MIN_AW = 11,
    parameter int MAX_AW = 13,
    localparam int SW_W  = DEC_AW - MIN_AW
) (
    input  logic [DEC_AW-1:0] cyc_addr,
    input  logic [SW_W-1:0]   base_sw,
    input  logic [1:0]        win_sel,
    output logic              match
);

    int unsigned win_aw;
    logic [SW_W-1:0] bit_ok;

    // Window size in address bits for the current jumper code
    always_comb win_aw = window_bits(win_sel, MIN_AW, MAX_AW);

    for (genvar i = 0; i < SW_W; i++) begin : g_bit
        // One compare per switch bit, forced true when below the window
        always_comb begin
            if (unsigned'(MIN_AW + i) < win_aw)
                bit_ok[i] = 1'b1;
            else
                bit_ok[i] = (cyc_addr[MIN_AW+i] == base_sw[i]);
        end
    end

    // All compared bits must agree
    always_comb match = &bit_ok;

endmodule

// File: rtl/brd_rom_addr_map.sv
// Maps the captured low address onto the EPROM so that a window smaller
// than the device lands on its top part. Bits at or above the window
// size are driven high.
module brd_rom_addr_map
    import boot_rom_pkg::*;
#(
    parameter int MIN_AW = 11,
    parameter int MAX_AW = 13
) (
    input  logic [MAX_AW-1:0] low_addr,
    input  logic [1:0]        win_sel,
    output logic [MAX_AW-1:0] rom_addr
);

    int unsigned win_aw;

    // Window size in address bits for the current jumper code
    always_comb win_aw = window_bits(win_sel, MIN_AW, MAX_AW);

    // Bits inside the smallest window always pass straight through
    always_comb rom_addr[MIN_AW-1:0] = low_addr[MIN_AW-1:0];

    for (genvar b = MIN_AW; b < MAX_AW; b++) begin : g_hi
        // Pass the bit inside the window, tie it high above
        always_comb rom_addr[b] = (unsigned'(b) < win_aw) ? low_addr[b] : 1'b1;
    end

endmodule

// File: rtl/boot_rom_decode.sv
// Boot ROM window decoder, top level.
// Captures each bus cycle at pSYNC, decides whether a memory read falls in
// the switch-selected window, and drives EPROM enables, EPROM address and
// the active-low Phantom line. Assumes dbin is only high inside a cycle.
module boot_rom_decode #(
    parameter int BUS_AW = 24,
    parameter int DEC_AW = 19,
    parameter int MIN_AW = 11,
    parameter int MAX_AW = 13,
    localparam int SW_W  = DEC_AW - MIN_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] addr,
    input  logic              smemr,
    input  logic              psync,
    input  logic              dbin,
    input  logic [SW_W-1:0]   base_sw,
    input  logic [1:0]        win_sel,
    output logic              rom_ce_n,
    output logic              rom_oe_n,
    output logic [MAX_AW-1:0] rom_addr,
    output logic              phantom_n
);

    logic [BUS_AW-1:0] cyc_addr;
    logic              cyc_memr;
    logic              in_window;
    logic              hit;

    brd_cycle_latch #(.BUS_AW(BUS_AW)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .psync    (psync),
        .addr_in  (addr),
        .memr_in  (smemr),
        .cyc_addr (cyc_addr),
        .cyc_memr (cyc_memr)
    );

    brd_window_match #(.DEC_AW(DEC_AW), .MIN_AW(MIN_AW), .MAX_AW(MAX_AW)) u_match (
        .cyc_addr (cyc_addr[DEC_AW-1:0]),
        .base_sw  (base_sw),
        .win_sel  (win_sel),
        .match    (in_window)
    );

    brd_rom_addr_map #(.MIN_AW(MIN_AW), .MAX_AW(MAX_AW)) u_map (
        .low_addr (cyc_addr[MAX_AW-1:0]),
        .win_sel  (win_sel),
        .rom_addr (rom_addr)
    );

    // A hit needs both a memory read and a window match
    always_comb hit = cyc_memr & in_window;

    // Active-low enables; output enable also waits for the read strobe
    always_comb begin
        rom_ce_n  = ~hit;
        phantom_n = ~hit;
        rom_oe_n  = ~(hit & dbin);
    end

endmodule

// File: rtl/boot_rom_decode_chk.sv
// Checker for boot_rom_decode, attached by bind below.
module boot_rom_decode_chk #(
    parameter int BUS_AW = 24,
    parameter int SW_W   = 8,
    parameter int MAX_AW = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BUS_AW-1:0] addr,
    input logic              smemr,
    input logic              psync,
    input logic              dbin,
    input logic [SW_W-1:0]   base_sw,
    input logic [1:0]        win_sel,
    input logic              rom_ce_n,
    input logic              rom_oe_n,
    input logic [MAX_AW-1:0] rom_addr,
    input logic              phantom_n
);

    // Reset leaves every enable released
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (rom_ce_n && rom_oe_n && phantom_n));

    // Non-read cycle never asserts Phantom
    assert_no_phantom_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (psync && !smemr) |=> phantom_n);

    // Read at the switch address with a 2kB window hits
    assert_hit_2k_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (psync && smemr && win_sel == 2'b00 && addr[18:11] == base_sw)
        |=> (!$stable(win_sel) || !$stable(base_sw) || !phantom_n));

    // Chip enable and Phantom move together
    assert_ce_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rom_ce_n == phantom_n);

    // Output enable only with read strobe inside a hit
    assert_oe_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_oe_n |-> (dbin && !phantom_n));

    // A 2kB window lands on the top of the device
    assert_top_map_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (win_sel == 2'b00) |-> (rom_addr[MAX_AW-1:MAX_AW-2] == 2'b11));

endmodule

bind boot_rom_decode boot_rom_decode_chk #(
    .BUS_AW (BUS_AW),
    .SW_W   (SW_W),
    .MAX_AW (MAX_AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .smemr     (smemr),
    .psync     (psync),
    .dbin      (dbin),
    .base_sw   (base_sw),
    .win_sel   (win_sel),
    .rom_ce_n  (rom_ce_n),
    .rom_oe_n  (rom_oe_n),
    .rom_addr  (rom_addr),
    .phantom_n (phantom_n)
);

// File: tb/sim_boot_rom_decode.sv
// Directed bench for boot_rom_decode: one task per scenario.
module sim_boot_rom_decode;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] addr = '0;
    logic        smemr = 1'b0;
    logic        psync = 1'b0;
    logic        dbin = 1'b0;
    logic [7:0]  base_sw = 8'h1F;
    logic [1:0]  win_sel = 2'b00;
    logic        rom_ce_n, rom_oe_n, phantom_n;
    logic [12:0] rom_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    boot_rom_decode u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .smemr(smemr), .psync(psync),
        .dbin(dbin), .base_sw(base_sw), .win_sel(win_sel), .rom_ce_n(rom_ce_n),
        .rom_oe_n(rom_oe_n), .rom_addr(rom_addr), .phantom_n(phantom_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One bus cycle: pSYNC for one edge, then sample after it
    task automatic bus_cycle(input logic [23:0] a, input logic rd);
        @(negedge clk);
        addr = a; smemr = rd; psync = 1'b1; dbin = 1'b0;
        @(negedge clk);
        psync = 1'b0;
    endtask

    // Check a hit or miss, including the dbin-gated output enable
    task automatic expect_hit(input string req, input bit exp_hit);
        check({req, " phantom"}, phantom_n, !exp_hit);
        check({req, " ce"},      rom_ce_n,  !exp_hit);
        check({req, " oe idle"}, rom_oe_n,  1'b1);
        dbin = 1'b1; #1;
        check({req, " oe data"}, rom_oe_n,  !exp_hit);
        dbin = 1'b0; #1;
    endtask

    task automatic t_reset;  // R1
        @(negedge clk);
        check("R1 ce", rom_ce_n, 1'b1);
        check("R1 oe", rom_oe_n, 1'b1);
        check("R1 phantom", phantom_n, 1'b1);
        rst_n = 1'b1;
    endtask

    task automatic t_default_read;  // R3 R6 R7 R8 R9
        win_sel = 2'b00; base_sw = 8'h1F;
        bus_cycle(24'h00FABC, 1'b1);
        expect_hit("R3 read FABC", 1'b1);
        check("R9 map 2k", rom_addr, 13'h1ABC);
        bus_cycle(24'h00F7FF, 1'b1);
        expect_hit("R3 below window", 1'b0);
    endtask

    task automatic t_write;  // R6
        bus_cycle(24'h00F800, 1'b0);
        expect_hit("R6 write", 1'b0);
    endtask

    task automatic t_hold;  // R2
        bus_cycle(24'h00F800, 1'b1);
        @(negedge clk);
        addr = 24'h000100; smemr = 1'b0;
        @(negedge clk);
        expect_hit("R2 hold", 1'b1);
        check("R2 addr held", rom_addr, 13'h1800);
    endtask

    task automatic t_windows;  // R4
        base_sw = 8'h1F; win_sel = 2'b01;
        bus_cycle(24'h00F123, 1'b1);
        expect_hit("R4 4k hit", 1'b1);
        check("R9 map 4k", rom_addr, 13'h1123);
        win_sel = 2'b00;
        bus_cycle(24'h00F123, 1'b1);
        expect_hit("R4 2k miss", 1'b0);
        win_sel = 2'b10;
        bus_cycle(24'h00E010, 1'b1);
        expect_hit("R4 8k hit", 1'b1);
        check("R9 map 8k", rom_addr, 13'h0010);
        win_sel = 2'b11;
        bus_cycle(24'h00E010, 1'b1);
        expect_hit("R4 code 11", 1'b1);
        win_sel = 2'b01;
        bus_cycle(24'h00E010, 1'b1);
        expect_hit("R4 4k miss", 1'b0);
        win_sel = 2'b00;
    endtask

    task automatic t_switch;  // R3
        base_sw = 8'h20; win_sel = 2'b00;
        bus_cycle(24'h010000, 1'b1);
        expect_hit("R3 sw 20", 1'b1);
        bus_cycle(24'h00F800, 1'b1);
        expect_hit("R3 old base", 1'b0);
        base_sw = 8'h1F;
    endtask

    task automatic t_alias;  // R5
        bus_cycle(24'h08F800, 1'b1);
        expect_hit("R5 alias 08F800", 1'b1);
        bus_cycle(24'hF8F800, 1'b1);
        expect_hit("R5 alias F8F800", 1'b1);
        bus_cycle(24'h04F800, 1'b1);
        expect_hit("R5 A18 set", 1'b0);
    endtask

    task automatic t_reset_mid;  // R1
        bus_cycle(24'h00F800, 1'b1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid ce", rom_ce_n, 1'b1);
        check("R1 mid phantom", phantom_n, 1'b1);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_default_read();
        t_write();
        t_hold();
        t_windows();
        t_switch();
        t_alias();
        t_reset_mid();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule